// File: doc/BRIEF.md
# Instruction Memory Bus Sequencer

The sequencer runs a short program of register writes out to the boards of a front-end readout bus. A host fills a small instruction store through a simple write port and then pulses `start`. From location 0 the block fetches each instruction word and decodes its target fields. It then takes the next word as write data and drives a single bus write. That write lasts until the addressed board acknowledges it or until a fixed wait limit runs out.

For every instruction it handles, the block writes a pair of status words to an external result memory. Software reads those words later to find which writes failed. The `busy` output acts as bit 0 of the host's run status. It rises on the cycle after an accepted start and falls when the program ends. A program ends at a dedicated end word or when the fetch pointer reaches the last location of the store.

Top module: `imem_bus_sequencer`

## Requirements
- R1: After reset, `busy`, `bus_req` and `res_we` are all 0.
- R2: A `start` pulse taken while idle begins fetching at location 0 and restarts result addressing at 0. `busy` is 1 from the next cycle until the run ends, and `bus_req` is only ever high while `busy` is high.
- R3: A word whose bits 23:20 equal 2 is a write command, and the word after it carries the write data in bits 19:0. The command bits map to the bus as follows: bit 18 drives `bus_bcast`, bit 17 drives `bus_to_ctrl`, and bits 4:0 drive `bus_regsel`. Bits 16:5 form the 12-bit hardware address. Within that address, bit 11 is `bus_branch`, bits 10:7 are `bus_board`, bits 6:4 are `bus_chip` and bits 3:0 are `bus_chan`.
- R4: `bus_req` stays high with steady fields and data until `bus_ack` is seen. An acknowledge in any of the first 16 request cycles counts as success, the 16th included, and `bus_req` drops on the cycle after it.
- R5: If no acknowledge arrives within 16 request cycles, the write fails and `bus_req` drops. Bit 20 of both result words for that instruction is then set, and the run goes on with the next instruction.
- R6: Each instruction produces two result writes on consecutive addresses, numbered from 0 in each run. The first word is bits 19:0 of the instruction word. The second word is the write data zero-extended. In both words bit 20 is the failure flag and all bits above it are 0.
- R7: The word 0x380000 ends the run. It produces no bus write and no result, and `busy` returns to 0.
- R8: The word at the last store location is never executed. When the fetch pointer reaches that location, the run ends even without an end word.
- R9: A word whose bits 23:20 are neither 2 nor part of the end word uses one store location and issues no bus write. It still logs two result words with bit 20 set, and the second of those words has its data bits at 0.
- R10: A `start` pulse that arrives while `busy` is 1 has no effect: the run continues and result addresses keep counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Instruction store write enable |
| host_addr | input | AW | Instruction store write address |
| host_wdata | input | WORD_W | Instruction store write word |
| start | input | 1 | Begin a run (ignored while busy) |
| busy | output | 1 | Run in progress (status bit 0) |
| bus_req | output | 1 | Bus write request |
| bus_bcast | output | 1 | Write goes to all targets |
| bus_to_ctrl | output | 1 | 1 = board controller, 0 = readout chip |
| bus_branch | output | 1 | Branch select |
| bus_board | output | 4 | Board number |
| bus_chip | output | 3 | Chip number |
| bus_chan | output | 4 | Channel number |
| bus_regsel | output | 5 | Register address |
| bus_wdata | output | DATA_W | Write data |
| bus_ack | input | 1 | Write acknowledge from the bus |
| res_we | output | 1 | Result memory write strobe |
| res_addr | output | AW+1 | Result memory address |
| res_wdata | output | WORD_W | Result word |

## Verification
An acknowledge can land in the same cycle as the wait counter's last step. The bench forces this with a bus responder that answers on exactly the 16th request cycle. The write must count as a success, so the expected result words for that instruction have bit 20 clear. A second collision is a host `start` that arrives while a run is in progress. The scoreboard checks every result address in order, so a restart would appear as an address that jumps back to 0.

// File: rtl/imseq_pkg.sv
package imseq_pkg;

  localparam logic [3:0] OP_WRITE = 4'h2;
  localparam int unsigned OP_LSB  = 20;
  localparam int unsigned ERR_BIT = 20;
  localparam logic [23:0] END_CODE = 24'h38_0000;

  typedef struct packed {
    logic       branch;
    logic [3:0] board;
    logic [2:0] chip;
    logic [3:0] chan;
  } hwaddr_t;

  typedef struct packed {
    logic       bcast;
    logic       to_ctrl;
    hwaddr_t    hw;
    logic [4:0] regsel;
  } wcmd_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DATA,
    ST_ISSUE,
    ST_LOG0,
    ST_LOG1
  } state_e;

  function automatic wcmd_t decode_cmd(input logic [18:0] bits);
    return wcmd_t'(bits);
  endfunction

endpackage

// File: rtl/imseq_store.sv
module imseq_store #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data
);

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/imseq_issue.sv
module imseq_issue #(
  parameter int unsigned TIMEOUT = 16,
  localparam int unsigned CW     = $clog2(TIMEOUT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic ack,
  output logic done,
  output logic failed
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          last_cycle;

  assign last_cycle = (cnt_q == CW'(TIMEOUT - 1));

  always_comb begin
    cnt_d  = '0;
    done   = 1'b0;
    failed = 1'b0;
    if (active) begin
      cnt_d  = cnt_q + 1'b1;
      done   = ack || last_cycle;
      failed = !ack && last_cycle;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/imem_bus_sequencer.sv
module imem_bus_sequencer
  import imseq_pkg::*;
#(
  parameter int unsigned IMEM_DEPTH = 64,
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned DATA_W     = 20,
  parameter int unsigned TIMEOUT    = 16,
  localparam int unsigned AW        = $clog2(IMEM_DEPTH),
  localparam int unsigned PC_W      = AW + 1,
  localparam int unsigned RES_AW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [AW-1:0]     host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  input  logic              start,
  output logic              busy,
  output logic              bus_req,
  output logic              bus_bcast,
  output logic              bus_to_ctrl,
  output logic              bus_branch,
  output logic [3:0]        bus_board,
  output logic [2:0]        bus_chip,
  output logic [3:0]        bus_chan,
  output logic [4:0]        bus_regsel,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  output logic              res_we,
  output logic [RES_AW-1:0] res_addr,
  output logic [WORD_W-1:0] res_wdata
);

  localparam logic [PC_W-1:0] LAST_LOC = PC_W'(IMEM_DEPTH - 1);

  // reset: asserted at once, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign rst_core_n = rst_pipe[1];

  state_e            state_q, state_d;
  logic [PC_W-1:0]   pc_q, pc_d;
  logic [RES_AW-1:0] rptr_q, rptr_d;
  logic [19:0]       cmd_q, cmd_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              err_q, err_d;

  logic [WORD_W-1:0] rd_data;
  logic              issue_done;
  logic              issue_failed;
  logic              fetch_end;
  logic              fetch_last;
  logic [3:0]        fetch_op;
  logic [19:0]       data_ext;
  wcmd_t             cmd_f;

  imseq_store #(
    .DEPTH  (IMEM_DEPTH),
    .WORD_W (WORD_W)
  ) u_store (
    .clk     (clk),
    .wr_en   (host_we),
    .wr_addr (host_addr),
    .wr_data (host_wdata),
    .rd_addr (pc_q[AW-1:0]),
    .rd_data (rd_data)
  );

  imseq_issue #(
    .TIMEOUT (TIMEOUT)
  ) u_issue (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .active (bus_req),
    .ack    (bus_ack),
    .done   (issue_done),
    .failed (issue_failed)
  );

  assign fetch_op   = rd_data[OP_LSB +: 4];
  assign fetch_end  = (rd_data == WORD_W'(END_CODE));
  assign fetch_last = (pc_q >= LAST_LOC);

  always_comb begin
    data_ext = '0;
    data_ext[DATA_W-1:0] = data_q;
  end

  always_comb begin
    state_d   = state_q;
    pc_d      = pc_q;
    rptr_d    = rptr_q;
    cmd_d     = cmd_q;
    data_d    = data_q;
    err_d     = err_q;
    res_we    = 1'b0;
    res_wdata = '0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_FETCH;
          pc_d    = '0;
          rptr_d  = '0;
        end
      end
      ST_FETCH: begin
        if (fetch_end || fetch_last) begin
          state_d = ST_IDLE;
        end else if (fetch_op == OP_WRITE) begin
          cmd_d   = rd_data[19:0];
          err_d   = 1'b0;
          pc_d    = pc_q + 1'b1;
          state_d = ST_DATA;
        end else begin
          cmd_d   = rd_data[19:0];
          data_d  = '0;
          err_d   = 1'b1;
          pc_d    = pc_q + 1'b1;
          state_d = ST_LOG0;
        end
      end
      ST_DATA: begin
        data_d  = rd_data[DATA_W-1:0];
        pc_d    = pc_q + 1'b1;
        state_d = ST_ISSUE;
      end
      ST_ISSUE: begin
        if (issue_done) begin
          err_d   = issue_failed;
          state_d = ST_LOG0;
        end
      end
      ST_LOG0: begin
        res_we             = 1'b1;
        res_wdata[19:0]    = cmd_q;
        res_wdata[ERR_BIT] = err_q;
        rptr_d             = rptr_q + 1'b1;
        state_d            = ST_LOG1;
      end
      ST_LOG1: begin
        res_we             = 1'b1;
        res_wdata[19:0]    = data_ext;
        res_wdata[ERR_BIT] = err_q;
        rptr_d             = rptr_q + 1'b1;
        state_d            = ST_FETCH;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= ST_IDLE;
      pc_q    <= '0;
      rptr_q  <= '0;
      cmd_q   <= '0;
      data_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      rptr_q  <= rptr_d;
      cmd_q   <= cmd_d;
      data_q  <= data_d;
      err_q   <= err_d;
    end
  end

  assign cmd_f       = decode_cmd(cmd_q[18:0]);
  assign busy        = (state_q != ST_IDLE);
  assign bus_req     = (state_q == ST_ISSUE);
  assign bus_bcast   = cmd_f.bcast;
  assign bus_to_ctrl = cmd_f.to_ctrl;
  assign bus_branch  = cmd_f.hw.branch;
  assign bus_board   = cmd_f.hw.board;
  assign bus_chip    = cmd_f.hw.chip;
  assign bus_chan    = cmd_f.hw.chan;
  assign bus_regsel  = cmd_f.regsel;
  assign bus_wdata   = data_q;
  assign res_addr    = rptr_q;

endmodule

// File: rtl/imseq_checker.sv
module imseq_checker #(
  parameter int unsigned TIMEOUT = 16,
  parameter int unsigned DATA_W  = 20,
  parameter int unsigned RES_AW  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              bus_req,
  input logic              bus_ack,
  input logic              bus_bcast,
  input logic              bus_to_ctrl,
  input logic              bus_branch,
  input logic [3:0]        bus_board,
  input logic [2:0]        bus_chip,
  input logic [3:0]        bus_chan,
  input logic [4:0]        bus_regsel,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              res_we,
  input logic [RES_AW-1:0] res_addr
);

  logic [DATA_W+24-1:0] fields;
  logic [7:0]           req_run;

  assign fields = {bus_bcast, bus_to_ctrl, bus_branch, bus_board, bus_chip,
                   bus_chan, bus_regsel, bus_wdata, 5'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_run <= '0;
    end else if (bus_req) begin
      req_run <= req_run + 1'b1;
    end else begin
      req_run <= '0;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_req && !res_we));

  assert_req_in_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> busy);

  assert_hold_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack && (req_run < 8'(TIMEOUT - 1))) |=> (bus_req && $stable(fields)));

  assert_ack_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack) |=> !bus_req);

  assert_wait_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (req_run < 8'(TIMEOUT)));

  assert_log_no_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> !bus_req);

  assert_pair_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_we && $past(res_we)) |-> (res_addr == $past(res_addr) + 1'b1));

endmodule

bind imem_bus_sequencer imseq_checker #(
  .TIMEOUT (TIMEOUT),
  .DATA_W  (DATA_W),
  .RES_AW  (RES_AW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .bus_req     (bus_req),
  .bus_ack     (bus_ack),
  .bus_bcast   (bus_bcast),
  .bus_to_ctrl (bus_to_ctrl),
  .bus_branch  (bus_branch),
  .bus_board   (bus_board),
  .bus_chip    (bus_chip),
  .bus_chan    (bus_chan),
  .bus_regsel  (bus_regsel),
  .bus_wdata   (bus_wdata),
  .res_we      (res_we),
  .res_addr    (res_addr)
);

// File: tb/imem_bus_sequencer_tb.sv
`timescale 1ns/100ps
module imem_bus_sequencer_tb;

  localparam int DEPTH  = 16;
  localparam int WORD_W = 32;
  localparam int DATA_W = 20;
  localparam int AW     = $clog2(DEPTH);

  logic              clk;
  logic              rst_n;
  logic              host_we;
  logic [AW-1:0]     host_addr;
  logic [WORD_W-1:0] host_wdata;
  logic              start;
  logic              busy;
  logic              bus_req;
  logic              bus_bcast;
  logic              bus_to_ctrl;
  logic              bus_branch;
  logic [3:0]        bus_board;
  logic [2:0]        bus_chip;
  logic [3:0]        bus_chan;
  logic [4:0]        bus_regsel;
  logic [DATA_W-1:0] bus_wdata;
  logic              bus_ack;
  logic              res_we;
  logic [AW:0]       res_addr;
  logic [WORD_W-1:0] res_wdata;

  imem_bus_sequencer #(
    .IMEM_DEPTH (DEPTH),
    .WORD_W     (WORD_W),
    .DATA_W     (DATA_W),
    .TIMEOUT    (16)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .start(start), .busy(busy), .bus_req(bus_req),
    .bus_bcast(bus_bcast), .bus_to_ctrl(bus_to_ctrl), .bus_branch(bus_branch),
    .bus_board(bus_board), .bus_chip(bus_chip), .bus_chan(bus_chan),
    .bus_regsel(bus_regsel), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .res_we(res_we), .res_addr(res_addr), .res_wdata(res_wdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // bus responder: acknowledges after a per-transaction number of request cycles
  int delays [64];
  int rcnt;
  int tidx;
  int nd;

  always @(posedge clk) begin
    if (!rst_n) begin
      rcnt <= 0;
      tidx <= 0;
    end else begin
      rcnt <= bus_req ? rcnt + 1 : 0;
      if (!bus_req && rcnt != 0) tidx <= tidx + 1;
    end
  end

  assign bus_ack = bus_req && (rcnt == delays[tidx]);

  // scoreboard
  logic [WORD_W-1:0] exp_bus [$];
  logic [WORD_W-1:0] exp_dat [$];
  logic [WORD_W-1:0] exp_res [$];
  int  exp_raddr;
  bit  req_seen;
  int  wp;

  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_req && !req_seen) begin
        req_seen = 1'b1;
        if (exp_bus.size() == 0) begin
          chk(1'b0, "R3 unexpected bus write", 0, 1);
        end else begin
          logic [WORD_W-1:0] e;
          logic [WORD_W-1:0] d;
          e = exp_bus.pop_front();
          d = exp_dat.pop_front();
          chk(bus_bcast == e[18], "R3 bcast", bus_bcast, e[18]);
          chk(bus_to_ctrl == e[17], "R3 target type", bus_to_ctrl, e[17]);
          chk(bus_branch == e[16], "R3 branch", bus_branch, e[16]);
          chk({bus_board, bus_chip, bus_chan} == e[15:5], "R3 board/chip/chan",
              {bus_board, bus_chip, bus_chan}, e[15:5]);
          chk(bus_regsel == e[4:0], "R3 regsel", bus_regsel, e[4:0]);
          chk(bus_wdata == d[DATA_W-1:0], "R3 data", bus_wdata, d[DATA_W-1:0]);
        end
      end
      if (!bus_req) req_seen = 1'b0;
      if (res_we) begin
        if (exp_res.size() == 0) begin
          chk(1'b0, "R6 unexpected result", res_wdata, 0);
        end else begin
          logic [WORD_W-1:0] r;
          r = exp_res.pop_front();
          chk(res_wdata == r, "R6 result word (R5/R9 flag)", res_wdata, r);
          chk(int'(res_addr) == exp_raddr, "R6 result addr (R10)", res_addr, exp_raddr);
          exp_raddr++;
        end
      end
    end
  end

  task automatic put(input logic [WORD_W-1:0] w);
    host_we    = 1'b1;
    host_addr  = AW'(wp);
    host_wdata = w;
    @(negedge clk);
    host_we    = 1'b0;
    wp++;
  endtask

  task automatic clear_store();
    wp = 0;
    for (int i = 0; i < DEPTH; i++) put(32'h0038_0000);
    wp = 0;
  endtask

  task automatic add_write(input bit bc, input bit ctl, input logic [11:0] hw,
                           input logic [4:0] rs, input logic [19:0] dat,
                           input int dly, input bit fail);
    logic [WORD_W-1:0] ins;
    ins = (32'h2 << 20) | (32'(bc) << 18) | (32'(ctl) << 17) | (32'(hw) << 5) | 32'(rs);
    put(ins);
    put(32'(dat));
    exp_bus.push_back(ins);
    exp_dat.push_back(32'(dat));
    delays[nd] = dly;
    nd++;
    exp_res.push_back((32'(fail) << 20) | (ins & 32'hF_FFFF));
    exp_res.push_back((32'(fail) << 20) | 32'(dat));
  endtask

  task automatic add_other(input logic [WORD_W-1:0] w);
    put(w);
    exp_res.push_back((32'h1 << 20) | (w & 32'hF_FFFF));
    exp_res.push_back(32'h1 << 20);
  endtask

  task automatic run_prog(input string tag, input int extra_start_at);
    int cyc;
    exp_raddr = 0;
    chk(busy == 1'b0, "R2 idle before start", busy, 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    cyc = 0;
    while (busy && cyc < 3000) begin
      start = (cyc == extra_start_at);
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(busy == 1'b0, {tag, " run ends, busy low"}, busy, 0);
    chk(exp_bus.size() == 0, {tag, " all bus writes seen"}, exp_bus.size(), 0);
    chk(exp_res.size() == 0, {tag, " all results seen"}, exp_res.size(), 0);
    repeat (3) @(negedge clk);
    chk(res_we == 1'b0 && bus_req == 1'b0, {tag, " quiet after end"}, {res_we, bus_req}, 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) delays[i] = 0;
    nd = 0; wp = 0; req_seen = 1'b0; exp_raddr = 0;
    host_we = 1'b0; host_addr = '0; host_wdata = '0; start = 1'b0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
    chk(bus_req == 1'b0, "R1 req after reset", bus_req, 0);
    chk(res_we == 1'b0, "R1 res_we after reset", res_we, 0);

    // R3 R4 R7: three writes, ack at once, after 3 cycles, on the 16th cycle
    clear_store();
    add_write(1'b0, 1'b0, 12'h8A5, 5'h06, 20'hABCDE, 0, 1'b0);
    add_write(1'b1, 1'b0, 12'h000, 5'h08, 20'h00002, 3, 1'b0);
    add_write(1'b0, 1'b1, 12'hFFF, 5'h1F, 20'hFFFFF, 15, 1'b0);
    put(32'h0038_0000);
    run_prog("R7 R4", -1);

    // R5: timeout, then execution continues
    clear_store();
    add_write(1'b1, 1'b1, 12'h47C, 5'h0B, 20'h12345, 40, 1'b1);
    add_write(1'b0, 1'b0, 12'h123, 5'h0C, 20'h00040, 1, 1'b0);
    put(32'h0038_0000);
    run_prog("R5", -1);

    // R9: non-write opcode
    clear_store();
    add_other(32'h0051_2345);
    add_write(1'b0, 1'b1, 12'h801, 5'h02, 20'h0BEEF, 2, 1'b0);
    put(32'h0038_0000);
    run_prog("R9", -1);

    // R10: start pulse mid-run is ignored
    clear_store();
    add_write(1'b0, 1'b0, 12'h300, 5'h01, 20'h00011, 10, 1'b0);
    add_write(1'b0, 1'b0, 12'h301, 5'h03, 20'h00022, 10, 1'b0);
    put(32'h0038_0000);
    run_prog("R10", 8);

    // R8: no end word, last location holds a write that must not run
    clear_store();
    add_other(32'h0001_2345);
    for (int k = 0; k < 7; k++) begin
      add_write(k[0], k[1], 12'(k * 291), 5'(k + 4), 20'(k * 4099), 0, 1'b0);
    end
    put(32'h0020_0ABC);
    run_prog("R8", -1);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule